// File: doc/BRIEF.md
# Control and Status Register Access Unit

This unit carries out the six atomic CSR instructions of a 32-bit RISC-V core: read/write, read-and-set and read-and-clear, each with a register operand or a 5-bit immediate operand. It owns a small register file. The file holds a 64-bit cycle counter, a 64-bit time counter, and a parameterised bank of general read/write registers placed at a configurable base address.

The execute stage presents one decoded instruction per cycle. That instruction carries a valid strobe, funct3, the 12-bit CSR address taken from the SYSTEM immediate, the rd index, the rs1 index (which is also the immediate) and the value read from rs1. In the same cycle the unit returns the value the CSR held before the instruction, together with a write enable for rd. It also returns a strobe that shows a CSR read actually took place, and a flag for an address that is not implemented. Any update to a general register takes effect at the next clock edge. A later instruction sees the new value, which makes each read-modify-write atomic.

Top module: `csr_unit`

## Requirements
- R1: funct3 selects the operation. 3'b001 is register read/write, 3'b010 is register set and 3'b011 is register clear. 3'b101, 3'b110 and 3'b111 are the immediate forms of the same three. Read/write stores the operand, and rd receives the value held before the instruction.
- R2: Set stores old OR operand, and clear stores old AND NOT operand. In both cases old is the value read in the same instruction.
- R3: In the immediate forms the operand is the 5-bit rs1 field, zero-extended to 32 bits. The rs1 value input is ignored.
- R4: For read/write forms with rd = 0, no read takes place. rd_fire_o is 0 and rd_data_o is 0, and the write still happens.
- R5: For set and clear forms with rs1 index 0 (a zero immediate), nothing is written, even if the rs1 value input is nonzero. The read still takes place, so rd_fire_o is 1.
- R6: The cycle counter advances by one on every clock after reset and starts at CNT_INIT. Address 12'hC00 reads bits 31:0 and 12'hC80 reads bits 63:32.
- R7: The time counter advances by one on each clock where tick_i is 1 and starts at CNT_INIT. Address 12'hC01 reads bits 31:0 and 12'hC81 reads bits 63:32.
- R8: The four counter addresses are read-only. Writes to them leave the counters unchanged and do not raise illegal_o.
- R9: An address that matches neither a counter nor a general register raises illegal_o. In that case rd_data_o, rd_we_o and rd_fire_o are 0 and no register changes.
- R10: rd_we_o is 1 exactly when a valid operation hits a legal address with rd not equal to 0. Register x0 is never written.
- R11: When req_valid_i is 0, or funct3 is 3'b000 or 3'b100, all outputs are 0 and no state changes.
- R12: General register k sits at address GP_BASE + k for k < NUM_GP. It resets to 0, and a write becomes visible to the next instruction.
- R13: During and just after reset, all general registers read 0 and both counters read CNT_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick, advances the time counter |
| req_valid_i | input | 1 | Instruction present this cycle |
| funct3_i | input | 3 | Operation select |
| addr_i | input | 12 | CSR address |
| rd_idx_i | input | 5 | Destination register index |
| rs1_idx_i | input | 5 | Source register index, also the immediate |
| rs1_val_i | input | 32 | Source register value |
| rd_data_o | output | 32 | Value of the CSR before the instruction |
| rd_we_o | output | 1 | Write enable for rd |
| rd_fire_o | output | 1 | A CSR read took place |
| illegal_o | output | 1 | Unimplemented CSR address |

## Verification
The bench uses NUM_GP = 3, which is not a power of two. With this setting the address just past the last general register falls inside the index width yet must still be flagged illegal. GP_BASE is 12'h7C0, and CNT_INIT is 64'h0000_0000_FFFF_FFF0. The cycle counter therefore carries into its upper half after 16 clocks, and the time counter does so after about 50 clocks. This puts both high-half addresses and the carry between halves within reach of a short run. A behavioural model in the bench predicts every output on every clock, for both directed cases and a pseudo-random instruction stream.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;
  localparam int XLEN  = 32;
  localparam int CNT_W = 2 * XLEN;

  typedef logic [XLEN-1:0]  word_t;
  typedef logic [CNT_W-1:0] count_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_CYC_LO,
    SRC_CYC_HI,
    SRC_TIM_LO,
    SRC_TIM_HI,
    SRC_GP
  } src_e;

  localparam logic [11:0] ADDR_CYC_LO = 12'hC00;
  localparam logic [11:0] ADDR_TIM_LO = 12'hC01;
  localparam logic [11:0] ADDR_CYC_HI = 12'hC80;
  localparam logic [11:0] ADDR_TIM_HI = 12'hC81;

  function automatic word_t imm_zext(logic [4:0] field);
    return word_t'(field);
  endfunction

  function automatic word_t csr_merge(csr_op_e op, word_t old, word_t opnd);
    case (op)
      OP_WRITE: return opnd;
      OP_SET:   return old | opnd;
      OP_CLEAR: return old & ~opnd;
      default:  return old;
    endcase
  endfunction
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_unit_pkg::*;
#(
  parameter int          NUM_GP  = 4,
  parameter logic [11:0] GP_BASE = 12'h7C0,
  localparam int         IDX_W   = (NUM_GP > 1) ? $clog2(NUM_GP) : 1
) (
  input  logic             valid,
  input  logic [2:0]       funct3,
  input  logic [11:0]      addr,
  input  logic [4:0]       rd_idx,
  input  logic [4:0]       rs1_idx,
  input  word_t            rs1_val,
  output csr_op_e          op,
  output word_t            operand,
  output src_e             src,
  output logic [IDX_W-1:0] gp_idx,
  output logic             active,
  output logic             legal,
  output logic             do_read,
  output logic             do_write
);
  logic [11:0] gp_off;
  logic        gp_hit;

  always_comb begin
    active  = valid && (funct3[1:0] != 2'b00);
    op      = active ? csr_op_e'(funct3[1:0]) : OP_NONE;
    operand = funct3[2] ? imm_zext(rs1_idx) : rs1_val;
    gp_off  = addr - GP_BASE;
    gp_hit  = 32'(gp_off) < NUM_GP;
    gp_idx  = gp_off[IDX_W-1:0];
    case (addr)
      ADDR_CYC_LO: src = SRC_CYC_LO;
      ADDR_CYC_HI: src = SRC_CYC_HI;
      ADDR_TIM_LO: src = SRC_TIM_LO;
      ADDR_TIM_HI: src = SRC_TIM_HI;
      default:     src = gp_hit ? SRC_GP : SRC_NONE;
    endcase
    legal    = (src != SRC_NONE);
    do_read  = active && legal && ((op != OP_WRITE) || (rd_idx != 5'd0));
    do_write = active && legal && (src == SRC_GP) &&
               ((op == OP_WRITE) || (rs1_idx != 5'd0));
  end
endmodule

// File: rtl/csr_counter.sv
module csr_counter
  import csr_unit_pkg::*;
#(
  parameter count_t INIT = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   inc,
  output count_t count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= INIT;
    else if (inc) count <= count + count_t'(1);
  end
endmodule

// File: rtl/csr_gp_file.sv
module csr_gp_file
  import csr_unit_pkg::*;
#(
  parameter  int NUM_GP = 4,
  localparam int IDX_W  = (NUM_GP > 1) ? $clog2(NUM_GP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  word_t            wdata,
  output word_t            q [NUM_GP]
);
  for (genvar i = 0; i < NUM_GP; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q[i] <= '0;
      else if (we && (idx == IDX_W'(i)))    q[i] <= wdata;
    end
  end
endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_unit_pkg::*;
#(
  parameter int          NUM_GP   = 4,
  parameter logic [11:0] GP_BASE  = 12'h7C0,
  parameter logic [63:0] CNT_INIT = 64'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        req_valid_i,
  input  logic [2:0]  funct3_i,
  input  logic [11:0] addr_i,
  input  logic [4:0]  rd_idx_i,
  input  logic [4:0]  rs1_idx_i,
  input  logic [31:0] rs1_val_i,
  output logic [31:0] rd_data_o,
  output logic        rd_we_o,
  output logic        rd_fire_o,
  output logic        illegal_o
);
  localparam int IDX_W = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;

  csr_op_e          op;
  word_t            operand;
  src_e             src;
  logic [IDX_W-1:0] gp_idx;
  logic             active, legal, do_read, do_write;

  count_t           cycle_q, time_q;
  word_t            gp_q [NUM_GP];
  word_t            cur_val, new_val;

  // named events for the checker
  logic             gp_wr_fire;
  assign gp_wr_fire = do_write;

  csr_decode #(.NUM_GP(NUM_GP), .GP_BASE(GP_BASE)) u_dec (
    .valid(req_valid_i), .funct3(funct3_i), .addr(addr_i),
    .rd_idx(rd_idx_i), .rs1_idx(rs1_idx_i), .rs1_val(rs1_val_i),
    .op(op), .operand(operand), .src(src), .gp_idx(gp_idx),
    .active(active), .legal(legal), .do_read(do_read), .do_write(do_write)
  );

  csr_counter #(.INIT(count_t'(CNT_INIT))) u_cycle (
    .clk(clk), .rst_n(rst_n), .inc(1'b1), .count(cycle_q)
  );

  csr_counter #(.INIT(count_t'(CNT_INIT))) u_time (
    .clk(clk), .rst_n(rst_n), .inc(tick_i), .count(time_q)
  );

  csr_gp_file #(.NUM_GP(NUM_GP)) u_gp (
    .clk(clk), .rst_n(rst_n), .we(do_write), .idx(gp_idx),
    .wdata(new_val), .q(gp_q)
  );

  always_comb begin
    cur_val = '0;
    case (src)
      SRC_CYC_LO: cur_val = cycle_q[XLEN-1:0];
      SRC_CYC_HI: cur_val = cycle_q[CNT_W-1:XLEN];
      SRC_TIM_LO: cur_val = time_q[XLEN-1:0];
      SRC_TIM_HI: cur_val = time_q[CNT_W-1:XLEN];
      SRC_GP: begin
        for (int i = 0; i < NUM_GP; i++)
          if (gp_idx == IDX_W'(i)) cur_val = gp_q[i];
      end
      default: cur_val = '0;
    endcase
    new_val = csr_merge(op, cur_val, operand);
  end

  assign rd_data_o = do_read ? cur_val : '0;
  assign rd_fire_o = do_read;
  assign rd_we_o   = active && legal && (rd_idx_i != 5'd0);
  assign illegal_o = active && !legal;
endmodule

// File: rtl/csr_unit_checker.sv
module csr_unit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        req_valid,
  input logic [2:0]  funct3,
  input logic [4:0]  rd_idx,
  input logic [4:0]  rs1_idx,
  input logic [31:0] rd_data,
  input logic        rd_we,
  input logic        rd_fire,
  input logic        illegal,
  input logic        gp_wr_fire,
  input logic [63:0] cycle_q,
  input logic [63:0] time_q
);
  p_x0_protected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_idx != 5'd0) && req_valid && !illegal);

  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (rd_data == 32'd0) && !rd_fire && !rd_we && !gp_wr_fire);

  p_rw_x0_noread_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && funct3[1:0] == 2'b01 && rd_idx == 5'd0) |-> !rd_fire && (rd_data == 32'd0));

  p_zero_mask_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && funct3[1] && rs1_idx == 5'd0) |-> !gp_wr_fire);

  p_idle_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !rd_fire && !rd_we && !illegal && !gp_wr_fire);

  p_cycle_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cycle_q == $past(cycle_q) + 64'd1);

  p_time_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_q));

  p_time_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> time_q == $past(time_q) + 64'd1);
endmodule

bind csr_unit csr_unit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_i), .req_valid(req_valid_i),
  .funct3(funct3_i), .rd_idx(rd_idx_i), .rs1_idx(rs1_idx_i),
  .rd_data(rd_data_o), .rd_we(rd_we_o), .rd_fire(rd_fire_o),
  .illegal(illegal_o), .gp_wr_fire(gp_wr_fire),
  .cycle_q(cycle_q), .time_q(time_q)
);

// File: tb/csr_unit_test.sv
module csr_unit_test;
  localparam int          CLK_P = 10;
  localparam int          NGP   = 3;
  localparam logic [11:0] GBASE = 12'h7C0;
  localparam logic [63:0] CINIT = 64'h0000_0000_FFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  funct3_i = 3'd0;
  logic [11:0] addr_i = 12'd0;
  logic [4:0]  rd_idx_i = 5'd0;
  logic [4:0]  rs1_idx_i = 5'd0;
  logic [31:0] rs1_val_i = 32'd0;
  logic [31:0] rd_data_o;
  logic        rd_we_o, rd_fire_o, illegal_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] m_cyc, m_tim;
  logic [31:0] m_gp [NGP];

  always #(CLK_P/2) clk = ~clk;

  csr_unit #(.NUM_GP(NGP), .GP_BASE(GBASE), .CNT_INIT(CINIT)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .req_valid_i(req_valid_i),
    .funct3_i(funct3_i), .addr_i(addr_i), .rd_idx_i(rd_idx_i),
    .rs1_idx_i(rs1_idx_i), .rs1_val_i(rs1_val_i), .rd_data_o(rd_data_o),
    .rd_we_o(rd_we_o), .rd_fire_o(rd_fire_o), .illegal_o(illegal_o)
  );

  function automatic bit is_gp(logic [11:0] a);
    return (a >= GBASE) && (a < GBASE + 12'(NGP));
  endfunction

  function automatic bit is_known(logic [11:0] a);
    return is_gp(a) || a == 12'hC00 || a == 12'hC01 || a == 12'hC80 || a == 12'hC81;
  endfunction

  function automatic logic [31:0] model_val(logic [11:0] a);
    if (a == 12'hC00) return m_cyc[31:0];
    if (a == 12'hC80) return m_cyc[63:32];
    if (a == 12'hC01) return m_tim[31:0];
    if (a == 12'hC81) return m_tim[63:32];
    if (is_gp(a))     return m_gp[int'(a - GBASE)];
    return 32'd0;
  endfunction

  // Drive one instruction just after a falling edge, compare, then advance the model.
  task automatic step(string tag, bit v, logic [2:0] f3, logic [11:0] a,
                      logic [4:0] rd, logic [4:0] rs1, logic [31:0] rv, bit tk);
    bit          op_ok, wr_form, set_form, clr_form, known, rd_en, wr_en;
    logic [31:0] opnd, cur, e_data, nxt;
    bit          e_we, e_fire, e_ill;
    op_ok    = v && (f3 == 3'd1 || f3 == 3'd2 || f3 == 3'd3 ||
                     f3 == 3'd5 || f3 == 3'd6 || f3 == 3'd7);
    wr_form  = (f3 == 3'd1 || f3 == 3'd5);
    set_form = (f3 == 3'd2 || f3 == 3'd6);
    clr_form = (f3 == 3'd3 || f3 == 3'd7);
    opnd     = (f3 >= 3'd5) ? {27'd0, rs1} : rv;
    known    = is_known(a);
    cur      = model_val(a);
    rd_en    = op_ok && known && (!wr_form || rd != 5'd0);
    wr_en    = op_ok && is_gp(a) && (wr_form || rs1 != 5'd0);
    e_fire   = rd_en;
    e_data   = rd_en ? cur : 32'd0;
    e_we     = op_ok && known && rd != 5'd0;
    e_ill    = op_ok && !known;
    nxt      = wr_form ? opnd : set_form ? (cur | opnd) : clr_form ? (cur & ~opnd) : cur;

    req_valid_i = v; funct3_i = f3; addr_i = a; rd_idx_i = rd;
    rs1_idx_i = rs1; rs1_val_i = rv; tick_i = tk;
    #1;
    checks++;
    if (rd_data_o !== e_data || rd_we_o !== e_we || rd_fire_o !== e_fire || illegal_o !== e_ill) begin
      errors++;
      $display("FAIL %s addr=%h f3=%0d: data %h/%h we %b/%b fire %b/%b ill %b/%b (actual/expected)",
               tag, a, f3, rd_data_o, e_data, rd_we_o, e_we, rd_fire_o, e_fire, illegal_o, e_ill);
    end
    @(posedge clk);
    m_cyc = m_cyc + 64'd1;
    if (tk) m_tim = m_tim + 64'd1;
    if (wr_en) m_gp[int'(a - GBASE)] = nxt;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_cyc = CINIT;
    m_tim = CINIT;
    for (int i = 0; i < NGP; i++) m_gp[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state: counters at CNT_INIT, general registers zero (read via set with x0 mask)
    step("R13", 1, 3'd2, 12'hC00, 5'd1, 5'd0, 32'd0, 0);
    step("R13", 1, 3'd2, 12'hC01, 5'd1, 5'd0, 32'd0, 0);
    step("R13", 1, 3'd2, GBASE,   5'd1, 5'd0, 32'd0, 0);
    step("R13", 1, 3'd2, GBASE + 12'd2, 5'd1, 5'd0, 32'd0, 0);

    // R1 R12 read/write, register form, then read back next instruction
    step("R1",  1, 3'd1, GBASE, 5'd3, 5'd4, 32'hA5A5_1234, 0);
    step("R12", 1, 3'd2, GBASE, 5'd3, 5'd0, 32'd0, 0);
    step("R1",  1, 3'd1, GBASE + 12'd1, 5'd7, 5'd9, 32'h0F0F_F0F0, 1);
    step("R12", 1, 3'd1, GBASE + 12'd1, 5'd7, 5'd9, 32'h1111_2222, 0);

    // R2 set and clear use the value just read
    step("R2", 1, 3'd2, GBASE, 5'd2, 5'd5, 32'h0000_FF00, 0);
    step("R2", 1, 3'd3, GBASE, 5'd2, 5'd5, 32'hA000_0F00, 0);
    step("R2", 1, 3'd2, GBASE, 5'd2, 5'd0, 32'd0, 0);

    // R3 immediate operand is the zero-extended rs1 field, rs1 value ignored
    step("R3", 1, 3'd5, GBASE + 12'd2, 5'd1, 5'h15, 32'hFFFF_FFFF, 0);
    step("R3", 1, 3'd6, GBASE + 12'd2, 5'd1, 5'h1F, 32'hFFFF_0000, 1);
    step("R3", 1, 3'd7, GBASE + 12'd2, 5'd1, 5'h05, 32'hFFFF_FFFF, 0);
    step("R3", 1, 3'd2, GBASE + 12'd2, 5'd1, 5'd0, 32'd0, 0);

    // R4 read/write with rd = x0: no read, write still lands
    step("R4", 1, 3'd1, GBASE, 5'd0, 5'd6, 32'hDEAD_BEEF, 0);
    step("R4", 1, 3'd5, GBASE + 12'd1, 5'd0, 5'h0A, 32'd0, 0);
    step("R4", 1, 3'd2, GBASE, 5'd1, 5'd0, 32'd0, 0);
    step("R4", 1, 3'd2, GBASE + 12'd1, 5'd1, 5'd0, 32'd0, 0);

    // R5 zero mask: no write even though rs1 value is nonzero, read still fires
    step("R5", 1, 3'd2, GBASE, 5'd8, 5'd0, 32'hFFFF_FFFF, 0);
    step("R5", 1, 3'd3, GBASE, 5'd8, 5'd0, 32'hFFFF_FFFF, 0);
    step("R5", 1, 3'd7, GBASE, 5'd8, 5'd0, 32'hFFFF_FFFF, 0);
    step("R5", 1, 3'd2, GBASE, 5'd8, 5'd0, 32'd0, 0);

    // R8 writes to counters ignored, no illegal flag
    step("R8", 1, 3'd1, 12'hC00, 5'd1, 5'd2, 32'd0, 0);
    step("R8", 1, 3'd2, 12'hC81, 5'd1, 5'd2, 32'hFFFF_FFFF, 0);
    step("R8", 1, 3'd2, 12'hC00, 5'd1, 5'd0, 32'd0, 0);

    // R9 unimplemented addresses, including one past the last general register
    step("R9", 1, 3'd1, GBASE + 12'd3, 5'd4, 5'd1, 32'h1234_5678, 0);
    step("R9", 1, 3'd2, 12'h123, 5'd4, 5'd1, 32'h1234_5678, 0);
    step("R9", 1, 3'd2, GBASE - 12'd1, 5'd4, 5'd0, 32'd0, 0);

    // R10 rd = x0 on set/clear: read fires, but no rd write enable
    step("R10", 1, 3'd3, GBASE, 5'd0, 5'd3, 32'h0000_0001, 0);
    step("R10", 1, 3'd2, GBASE, 5'd31, 5'd0, 32'd0, 0);

    // R11 idle or reserved funct3: nothing happens
    step("R11", 0, 3'd1, GBASE, 5'd1, 5'd1, 32'hFFFF_FFFF, 0);
    step("R11", 1, 3'd0, GBASE, 5'd1, 5'd1, 32'hFFFF_FFFF, 0);
    step("R11", 1, 3'd4, GBASE, 5'd1, 5'd1, 32'hFFFF_FFFF, 0);
    step("R11", 1, 3'd2, GBASE, 5'd1, 5'd0, 32'd0, 0);

    // R6 R7 counters across the carry into the upper half
    for (int i = 0; i < 80; i++) begin
      logic [11:0] a;
      case (i % 4)
        0: a = 12'hC00;
        1: a = 12'hC80;
        2: a = 12'hC01;
        default: a = 12'hC81;
      endcase
      step((i % 4 < 2) ? "R6" : "R7", 1, 3'd2, a, 5'd1, 5'd0, 32'd0, (i % 3) != 0);
    end

    // R1/R2/R3 mixed pseudo-random stream
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      case ($urandom % 8)
        0: a = GBASE;
        1: a = GBASE + 12'd1;
        2: a = GBASE + 12'd2;
        3: a = GBASE + 12'd3;
        4: a = 12'hC00;
        5: a = 12'hC81;
        6: a = 12'hC01;
        default: a = 12'h345;
      endcase
      step("R1/R2/R3", ($urandom % 8) != 0, 3'($urandom), a, 5'($urandom % 4),
           5'($urandom % 6), $urandom, $urandom % 2);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule